// File: doc/BRIEF.md
# Single-Pass Bounding-Box Labeler

This block finds the connected foreground regions of a binary image that arrives in raster order, one pixel per accepted cycle, and reports the bounding rectangle of each region once the region can no longer grow. It never stores a labeled image. It keeps the labels of the previous row in a line buffer, a label equivalence table, a rectangle table, a per-label "touched in the latest row" flag, and a FIFO of labels that can be handed out again.

Work alternates between two phases. During a row scan each pixel is labeled from its four already-seen neighbours (up-left, up, up-right, left). Two regions that meet are merged at once: the larger root is pointed at the smaller, and the two rectangles are combined. After the last pixel of a row the block drops its ready signal and walks the table, one entry per cycle. Untouched roots are reported and freed. Untouched non-roots are recycled. Touched non-roots have their pointer shortened to the root. An end-of-frame marker makes the final walk treat every label as untouched, so everything left is flushed.

The pixel source must hold a pixel while ready is low. A downstream filter, which is not part of this block, consumes the rectangle records.

Top module: `ccl_bbox_labeler`

## Requirements
- R1: After reset `pix_ready` is 1 and `box_valid` is 0.
- R2: While a row is being scanned, every offered pixel is taken in the cycle it is offered. `pix_ready` stays 1 from the first pixel of a row through its end-of-row pixel.
- R3: In the cycle after an end-of-row pixel is accepted, `pix_ready` is 0. It stays 0 for at least 1 and at most LABELS-1 cycles, then returns to 1.
- R4: Foreground pixels that touch at an edge or only at a corner (8-connectivity) belong to one region. A diagonal staircase produces a single record.
- R5: Each region produces exactly one record holding the minimum and maximum column and row of its pixels. The column is the pixel's position within its row, counted from 0. The row is the number of end-of-row markers seen since the frame began.
- R6: Branches that are first seen as separate and join in a later row (U shapes, merges from the up-right and left sides) produce one record that covers all branches, and no record for any branch alone.
- R7: A region with bottom row ymax is reported during the table walk that follows row ymax+1. If ymax is the last row of the frame, it is reported in that frame's final walk. `box_valid` is high only in the cycle after a cycle in which `pix_ready` was 0.
- R8: The end-of-frame marker, given together with end-of-row on the last pixel, flushes every remaining region. The next frame restarts at row 0 and treats the row above its first row as background, so regions never join across frames.
- R9: Label numbers are reused through the release FIFO. A frame may contain more regions than LABELS-1 in total, as long as the labels live at any one time fit within LABELS-1. The allocation counter restarts with each frame.
- R10: Every record is a single-cycle `box_valid` pulse with `box_xmin` <= `box_xmax` and `box_ymin` <= `box_ymax`.
- R11: Cycles with `pix_valid` low have no effect, whatever the values of the pixel bit and markers. Background pixels create no region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pix_valid | input | 1 | Pixel offered |
| pix_bit | input | 1 | 1 = foreground |
| pix_eol | input | 1 | Last pixel of the row |
| pix_eof | input | 1 | Last pixel of the frame (given together with pix_eol) |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| box_valid | output | 1 | Rectangle record strobe |
| box_xmin | output | $clog2(IMG_W) | Leftmost column |
| box_xmax | output | $clog2(IMG_W) | Rightmost column |
| box_ymin | output | $clog2(IMG_H) | Top row |
| box_ymax | output | $clog2(IMG_H) | Bottom row |

## Verification
Several properties are checked on every cycle by the assertions:
- ready falls after each end-of-row and stays low for a bounded time;
- records appear only right after a walk cycle and are well ordered;
- every merge pointer points to a smaller label;
- the release FIFO never overflows or underflows;
- a fresh label is always available.

Whether the reported rectangles are the true connected components, and whether each is reported in the right row's walk, can only be shown by the bench scenarios. The bench compares every record with a flood-fill reference over directed shapes, dense and sparse pseudo-random frames, back-to-back frames and frames with idle gaps carrying garbage.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

    typedef enum logic {
        MODE_SCAN  = 1'b0,
        MODE_SWEEP = 1'b1
    } mode_e;

endpackage

// File: rtl/ccl_line_buf.sv
module ccl_line_buf #(
    parameter int DEPTH = 16,
    parameter int LW    = 4,
    localparam int XW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] rd_x,
    output logic [LW-1:0] rd_up,
    output logic [LW-1:0] rd_ur,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_x,
    input  logic [LW-1:0] wr_lab
);

    typedef logic [DEPTH-1:0][LW-1:0] line_t;

    line_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_x] = wr_lab;
        end
        rd_up = mem_q[rd_x];
        if (int'(rd_x) + 1 < DEPTH) begin
            rd_ur = mem_q[XW'(int'(rd_x) + 1)];
        end else begin
            rd_ur = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_x) < DEPTH)); // R2

endmodule

// File: rtl/ccl_free_queue.sv
module ccl_free_queue #(
    parameter int DEPTH = 16,
    parameter int LW    = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [LW-1:0] push_lab,
    input  logic          pop,
    output logic          empty,
    output logic [LW-1:0] head
);

    typedef struct packed {
        logic [DEPTH-1:0][LW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } fq_t;

    fq_t d, q;
    logic full;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign head  = q.mem[q.rd];

    always_comb begin
        d = q;
        if (clr) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (push) begin
                d.mem[q.wr] = push_lab;
                d.wr        = bump(q.wr);
            end
            if (pop) begin
                d.rd = bump(q.rd);
            end
            d.cnt = q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> !full); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> !empty); // R9

endmodule

// File: rtl/ccl_bbox_labeler.sv
module ccl_bbox_labeler #(
    parameter int IMG_W  = 16,
    parameter int IMG_H  = 16,
    parameter int LABELS = 16,
    localparam int XW    = $clog2(IMG_W),
    localparam int YW    = $clog2(IMG_H),
    localparam int LW    = $clog2(LABELS),
    localparam int CW    = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          pix_bit,
    input  logic          pix_eol,
    input  logic          pix_eof,
    output logic          pix_ready,
    output logic          box_valid,
    output logic [XW-1:0] box_xmin,
    output logic [XW-1:0] box_xmax,
    output logic [YW-1:0] box_ymin,
    output logic [YW-1:0] box_ymax
);

    import ccl_pkg::*;

    typedef struct packed {
        logic [XW-1:0] xmin;
        logic [XW-1:0] xmax;
        logic [YW-1:0] ymin;
        logic [YW-1:0] ymax;
    } bbox_t;

    typedef logic [LABELS-1:0][LW-1:0] merge_t;

    typedef struct packed {
        mode_e                    mode;
        logic [XW-1:0]            x;
        logic [YW-1:0]            y;
        logic                     first_row;
        logic [LW-1:0]            left;
        logic [LW-1:0]            ul;
        logic [CW-1:0]            cnt;
        logic [LW-1:0]            idx;
        logic                     flush;
        logic                     box_v;
        bbox_t                    box;
        merge_t                   merge;
        logic [LABELS-1:0]        active;
        logic [LABELS-1:0]        used;
        bbox_t [LABELS-1:0]       bbox;
    } state_t;

    state_t d, q;

    // line buffer and release queue hookup
    logic [LW-1:0] lb_up, lb_ur, lb_wlab;
    logic          lb_we;
    logic          fq_clr, fq_push, fq_pop, fq_empty;
    logic [LW-1:0] fq_push_lab, fq_head;

    // scan-phase intermediates
    logic [3:0][LW-1:0] nb, rt;
    logic [LW-1:0]      tgt, new_lab, cur_lab;
    logic               need_new;
    bbox_t              ubox;
    logic [LW-1:0]      sw_i;
    logic               sw_in_range, sw_last, sw_act, sw_root;

    function automatic logic [LW-1:0] find_root(input merge_t m, input logic [LW-1:0] l);
        logic [LW-1:0] r;
        r = l;
        for (int k = 0; k < LABELS; k++) begin
            r = m[r];
        end
        return r;
    endfunction

    ccl_line_buf #(.DEPTH(IMG_W), .LW(LW)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_x   (q.x),
        .rd_up  (lb_up),
        .rd_ur  (lb_ur),
        .wr_en  (lb_we),
        .wr_x   (q.x),
        .wr_lab (lb_wlab)
    );

    ccl_free_queue #(.DEPTH(LABELS), .LW(LW)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fq_clr),
        .push     (fq_push),
        .push_lab (fq_push_lab),
        .pop      (fq_pop),
        .empty    (fq_empty),
        .head     (fq_head)
    );

    always_comb begin
        d           = q;
        d.box_v     = 1'b0;
        lb_we       = 1'b0;
        lb_wlab     = '0;
        fq_clr      = 1'b0;
        fq_push     = 1'b0;
        fq_push_lab = '0;
        fq_pop      = 1'b0;

        // neighbours: up-left, up, up-right, left
        nb[0] = (q.x == '0) ? '0 : q.ul;
        nb[1] = q.first_row ? '0 : lb_up;
        nb[2] = q.first_row ? '0 : lb_ur;
        nb[3] = (q.x == '0) ? '0 : q.left;
        tgt   = '0;
        ubox  = '{xmin: q.x, xmax: q.x, ymin: q.y, ymax: q.y};
        for (int k = 0; k < 4; k++) begin
            rt[k] = (nb[k] == '0) ? '0 : find_root(q.merge, nb[k]);
            if (rt[k] != '0) begin
                if (tgt == '0 || rt[k] < tgt) tgt = rt[k];
                if (q.bbox[rt[k]].xmin < ubox.xmin) ubox.xmin = q.bbox[rt[k]].xmin;
                if (q.bbox[rt[k]].xmax > ubox.xmax) ubox.xmax = q.bbox[rt[k]].xmax;
                if (q.bbox[rt[k]].ymin < ubox.ymin) ubox.ymin = q.bbox[rt[k]].ymin;
                if (q.bbox[rt[k]].ymax > ubox.ymax) ubox.ymax = q.bbox[rt[k]].ymax;
            end
        end
        need_new = pix_bit && (tgt == '0);
        new_lab  = fq_empty ? q.cnt[LW-1:0] : fq_head;
        cur_lab  = need_new ? new_lab : tgt;

        // sweep-phase intermediates
        sw_i        = q.idx;
        sw_in_range = ({1'b0, q.idx} < q.cnt);
        sw_last     = (({1'b0, q.idx} + 1'b1) >= q.cnt);
        sw_act      = q.active[sw_i] && !q.flush;
        sw_root     = (q.merge[sw_i] == sw_i);

        case (q.mode)
            MODE_SCAN: begin
                if (pix_valid) begin
                    lb_we   = 1'b1;
                    lb_wlab = pix_bit ? cur_lab : '0;
                    d.left  = pix_bit ? cur_lab : '0;
                    d.ul    = nb[1];
                    if (pix_bit) begin
                        if (need_new) begin
                            if (fq_empty) d.cnt = q.cnt + 1'b1;
                            else          fq_pop = 1'b1;
                            d.merge[new_lab] = new_lab;
                        end else begin
                            for (int k = 0; k < 4; k++) begin
                                if (rt[k] != '0 && rt[k] != tgt) d.merge[rt[k]] = tgt;
                            end
                        end
                        d.bbox[cur_lab]   = ubox;
                        d.used[cur_lab]   = 1'b1;
                        d.active[cur_lab] = 1'b1;
                    end
                    if (pix_eol) begin
                        d.x         = '0;
                        d.y         = q.y + 1'b1;
                        d.first_row = 1'b0;
                        d.mode      = MODE_SWEEP;
                        d.idx       = LW'(1);
                        d.flush     = pix_eof;
                    end else begin
                        d.x = q.x + 1'b1;
                    end
                end
            end
            MODE_SWEEP: begin
                if (sw_in_range) begin
                    if (q.used[sw_i]) begin
                        if (!sw_act) begin
                            if (sw_root) begin
                                d.box_v = 1'b1;
                                d.box   = q.bbox[sw_i];
                            end
                            d.used[sw_i] = 1'b0;
                            fq_push      = 1'b1;
                            fq_push_lab  = sw_i;
                        end else if (!sw_root) begin
                            d.merge[sw_i] = q.merge[q.merge[sw_i]];
                        end
                    end
                    d.active[sw_i] = 1'b0;
                end
                if (sw_last) begin
                    d.mode = MODE_SCAN;
                    if (q.flush) begin
                        d.flush     = 1'b0;
                        d.cnt       = CW'(1);
                        d.y         = '0;
                        d.first_row = 1'b1;
                        d.active    = '0;
                        fq_clr      = 1'b1;
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.mode = MODE_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.cnt       <= CW'(1);
            q.first_row <= 1'b1;
            for (int i = 0; i < LABELS; i++) begin
                q.merge[i] <= LW'(i);
            end
        end else begin
            q <= d;
        end
    end

    assign pix_ready = (q.mode == MODE_SCAN);
    assign box_valid = q.box_v;
    assign box_xmin  = q.box.xmin;
    assign box_xmax  = q.box.xmax;
    assign box_ymin  = q.box.ymin;
    assign box_ymax  = q.box.ymax;

    // length of the current ready-low stretch, for the bound check
    logic [CW-1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_run_q <= '0;
        else if (!pix_ready) low_run_q <= low_run_q + 1'b1;
        else                 low_run_q <= '0;
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && pix_eol) |=> !pix_ready); // R3
    AST_SWEEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ready |-> (low_run_q < CW'(LABELS - 1))); // R3
    AST_BOX_AFTER_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        box_valid |-> $past(!pix_ready)); // R7
    AST_BOX_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        box_valid |-> (box_xmin <= box_xmax && box_ymin <= box_ymax)); // R10
    AST_LABEL_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && need_new) |-> (!fq_empty || q.cnt < CW'(LABELS))); // R9

    for (genvar gi = 1; gi < LABELS; gi++) begin : g_merge_chk
        AST_MERGE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            q.merge[gi] <= LW'(gi)); // R6
    end

endmodule

// File: tb/ccl_bbox_labeler_tb.sv
module ccl_bbox_labeler_tb;

    localparam int CLK_P = 10;
    localparam int W     = 8;
    localparam int H     = 8;
    localparam int L     = 16;
    localparam int XW    = $clog2(W);
    localparam int YW    = $clog2(H);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_bit = 1'b0, pix_eol = 1'b0, pix_eof = 1'b0;
    logic pix_ready, box_valid;
    logic [XW-1:0] box_xmin, box_xmax;
    logic [YW-1:0] box_ymin, box_ymax;

    ccl_bbox_labeler #(.IMG_W(W), .IMG_H(H), .LABELS(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_bit(pix_bit),
        .pix_eol(pix_eol), .pix_eof(pix_eof), .pix_ready(pix_ready),
        .box_valid(box_valid), .box_xmin(box_xmin), .box_xmax(box_xmax),
        .box_ymin(box_ymin), .box_ymax(box_ymax)
    );

    always #(CLK_P / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int row_cnt = 0;
    int low_run = 0;
    string cur_tag = "R5";
    int unsigned seed = 32'h1234_5678;

    logic img [H][W];
    int ex_n;
    int ex_xmin[W*H], ex_xmax[W*H], ex_ymin[W*H], ex_ymax[W*H];
    bit ex_found[W*H];

    function automatic int unsigned nxt();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // flood-fill reference, 8-connectivity
    task automatic compute_expected();
        int lab [H][W];
        int sx[W*H], sy[W*H];
        int sp;
        ex_n = 0;
        for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) lab[y][x] = 0;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                if (img[y][x] && lab[y][x] == 0) begin
                    ex_xmin[ex_n] = x; ex_xmax[ex_n] = x;
                    ex_ymin[ex_n] = y; ex_ymax[ex_n] = y;
                    ex_found[ex_n] = 1'b0;
                    lab[y][x] = ex_n + 1;
                    sp = 0; sx[0] = x; sy[0] = y; sp = 1;
                    while (sp > 0) begin
                        int cx, cy;
                        sp--; cx = sx[sp]; cy = sy[sp];
                        if (cx < ex_xmin[ex_n]) ex_xmin[ex_n] = cx;
                        if (cx > ex_xmax[ex_n]) ex_xmax[ex_n] = cx;
                        if (cy < ex_ymin[ex_n]) ex_ymin[ex_n] = cy;
                        if (cy > ex_ymax[ex_n]) ex_ymax[ex_n] = cy;
                        for (int dy = -1; dy <= 1; dy++) begin
                            for (int dx = -1; dx <= 1; dx++) begin
                                int nx, ny;
                                nx = cx + dx; ny = cy + dy;
                                if (nx >= 0 && nx < W && ny >= 0 && ny < H) begin
                                    if (img[ny][nx] && lab[ny][nx] == 0) begin
                                        lab[ny][nx] = ex_n + 1;
                                        sx[sp] = nx; sy[sp] = ny; sp++;
                                    end
                                end
                            end
                        end
                    end
                    ex_n++;
                end
            end
        end
    endtask

    // record monitor: match against reference, check reporting row (R7)
    always @(negedge clk) begin
        if (rst_n && box_valid) begin
            int hit;
            hit = -1;
            for (int k = 0; k < ex_n; k++) begin
                if (hit < 0 && !ex_found[k] && ex_xmin[k] == int'(box_xmin) &&
                    ex_xmax[k] == int'(box_xmax) && ex_ymin[k] == int'(box_ymin) &&
                    ex_ymax[k] == int'(box_ymax)) hit = k;
            end
            checks++;
            if (hit < 0) begin
                errors++;
                $display("FAIL %s: unexpected record x[%0d..%0d] y[%0d..%0d] expected=an unreported reference region",
                         cur_tag, box_xmin, box_xmax, box_ymin, box_ymax);
            end else begin
                int exp_row;
                ex_found[hit] = 1'b1;
                exp_row = (ex_ymax[hit] + 1 < H) ? ex_ymax[hit] + 1 : H - 1;
                check(row_cnt - 1 == exp_row, "R7", "record reported after row", row_cnt - 1, exp_row);
            end
        end
    end

    // ready-low stretch length (R3)
    always @(negedge clk) begin
        if (rst_n) begin
            if (!pix_ready) low_run++;
            else if (low_run > 0) begin
                check(low_run >= 1 && low_run <= L - 1, "R3", "ready-low stretch length", low_run, L - 1);
                low_run = 0;
            end
        end
    end

    task automatic run_frame(input string tag, input bit gaps);
        int stalls;
        cur_tag = tag;
        compute_expected();
        row_cnt = 0;
        for (int y = 0; y < H; y++) begin
            stalls = 0;
            for (int x = 0; x < W; x++) begin
                if (gaps && ((x + y) % 3 == 0)) begin
                    @(negedge clk);
                    pix_valid = 1'b0; pix_bit = 1'b1; pix_eol = 1'b1; pix_eof = 1'b1;
                end
                @(negedge clk);
                while (!pix_ready) begin
                    if (x != 0) stalls++;
                    pix_valid = 1'b0;
                    @(negedge clk);
                end
                pix_valid = 1'b1;
                pix_bit   = img[y][x];
                pix_eol   = (x == W - 1);
                pix_eof   = (x == W - 1) && (y == H - 1);
                if (x == W - 1) row_cnt++;
            end
            @(negedge clk);
            pix_valid = 1'b0; pix_bit = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
            check(pix_ready == 1'b0, "R3", "ready after end-of-row", int'(pix_ready), 0);
            check(stalls == 0, "R2", "stalls inside a row", stalls, 0);
        end
        while (!pix_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        for (int k = 0; k < ex_n; k++) begin
            check(ex_found[k], tag, "reference region reported (count)", int'(ex_found[k]), 1);
        end
        ex_n = 0;
    endtask

    task automatic clear_img();
        for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        ex_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_ready == 1'b1, "R1", "ready after reset", int'(pix_ready), 1);
        check(box_valid == 1'b0, "R1", "box_valid after reset", int'(box_valid), 0);

        // R11: empty frame yields nothing
        clear_img();
        run_frame("R11", 1'b1);

        // R4: diagonal staircase
        clear_img();
        for (int i = 0; i < 6; i++) img[i][i + 1] = 1'b1;
        run_frame("R4", 1'b0);

        // R6: U shape joined at the bottom, and up-right/left merge
        clear_img();
        for (int y = 0; y < 5; y++) begin img[y][1] = 1'b1; img[y][5] = 1'b1; end
        for (int x = 1; x <= 5; x++) img[5][x] = 1'b1;
        run_frame("R6", 1'b0);
        clear_img();
        img[0][3] = 1'b1; img[1][0] = 1'b1; img[1][1] = 1'b1; img[1][2] = 1'b1;
        img[3][7] = 1'b1; img[4][6] = 1'b1; img[4][4] = 1'b1; img[4][5] = 1'b1;
        run_frame("R6", 1'b0);

        // R5: separate regions at the corners and edges
        clear_img();
        img[0][0] = 1'b1; img[0][7] = 1'b1; img[1][7] = 1'b1;
        img[7][0] = 1'b1; img[7][1] = 1'b1; img[6][7] = 1'b1; img[7][7] = 1'b1;
        img[3][3] = 1'b1; img[3][4] = 1'b1; img[4][3] = 1'b1;
        run_frame("R5", 1'b0);

        // R6: full frame is one region
        for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = 1'b1;
        run_frame("R6", 1'b0);

        // R8: last row of one frame and first row of the next stay apart
        clear_img();
        for (int x = 2; x < 6; x++) img[7][x] = 1'b1;
        run_frame("R8", 1'b0);
        clear_img();
        for (int x = 2; x < 6; x++) img[0][x] = 1'b1;
        run_frame("R8", 1'b0);

        // R9: 16 isolated dots, more regions than labels
        clear_img();
        for (int y = 0; y < H; y += 2) for (int x = 0; x < W; x += 2) img[y][x] = 1'b1;
        run_frame("R9", 1'b0);

        // R10 / R11: pseudo-random frames, some with idle gaps carrying garbage
        for (int f = 0; f < 60; f++) begin
            int thr;
            thr = 15 + (f * 7) % 70;
            for (int y = 0; y < H; y++)
                for (int x = 0; x < W; x++)
                    img[y][x] = ((nxt() % 100) < thr);
            run_frame((f % 2 == 0) ? "R10" : "R11", (f % 2 == 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule